// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit charge-redistribution converter. It takes a clock, a level run request and the one-bit comparator decision. It steps through a fixed conversion frame. The frame opens with a sample window, where the input is tracked onto the capacitor array and every DAC bit switch is grounded. A binary search follows, one bit per clock, most significant bit first. The frame closes with an end-of-conversion flag. The DAC trial word, the sample-switch control and the comparator strobes are all outputs. The capacitor array, switches and comparator stay outside the block.

After the run request rises from idle, a two-cycle arming phase runs before the first frame. While the request stays high, frames follow one another with no gap. If the request drops during a frame, that frame still finishes, and the sequencer then parks in idle. The converted code is loaded into a result register in one step at end-of-conversion. It stays unchanged until the next end-of-conversion.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is applied mid-frame, `arming`, `samp_on`, `pre_rst`, `lat_stb` and `eoc` are 0, and `dac_word` and `result` are 0.
- R2: When `run_en` is seen high at a clock edge while idle, `arming` is high for exactly the next two cycles. The first sample cycle follows immediately after them.
- R3: A frame lasts exactly 12 cycles: 3 sample cycles, 8 bit cycles, 1 end cycle. While `run_en` stays high, the next frame's first sample cycle directly follows the end cycle. In any cycle, at most one of `arming`, `samp_on`, `lat_stb` and `eoc` is high.
- R4: In every sample cycle, `samp_on` is 1, `dac_word` is 0 and `lat_stb` is 0.
- R5: Bit cycle k (k = 0..7) tests bit 7-k. In it, `dac_word` carries the already decided higher bits, a 1 in bit 7-k, and 0 in all lower bits.
- R6: A comparator value of 0 in a bit cycle keeps the trial bit at 1. A value of 1 clears it to 0. With a comparator that outputs 1 exactly when `dac_word` exceeds the input code, `result` equals that input code.
- R7: `lat_stb` is high in every bit cycle and in no other cycle. `pre_rst` is high in every sample and end cycle, low in bit cycles and low while idle or arming.
- R8: `eoc` is high for exactly one cycle, the cycle right after the last bit cycle. `result` takes the new code at the same clock edge where `eoc` rises.
- R9: `result` changes only at the edge where `eoc` rises. It holds its value through sample, bit, idle and arming cycles.
- R10: If `run_en` falls during a frame, the frame completes with its end cycle, and the sequencer then goes idle with no further sample cycles. Raising `run_en` again goes through the two-cycle arming phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Level request to run conversions |
| cmp_out | input | 1 | Comparator decision, 1 means trial word above input |
| arming | output | 1 | Start-up enable, high for two cycles before the first frame |
| samp_on | output | 1 | Sample switch control |
| pre_rst | output | 1 | Comparator preamplifier reset |
| lat_stb | output | 1 | Comparator output latch strobe, one per bit decision |
| dac_word | output | 8 | DAC bit-switch control word (trial word) |
| eoc | output | 1 | End-of-conversion, one cycle per frame |
| result | output | 8 | Converted code, held between conversions |

## Verification
Several properties are checked on every cycle. The phase outputs are mutually exclusive. The DAC word is zero while sampling. The preamplifier reset never overlaps the latch strobe. End-of-conversion is a single cycle that directly follows a bit decision. The result moves only with that pulse, and arming hands over straight into sampling.

Other properties need the bench's scenarios. These are the exact trial-word sequence for a given input code, the comparator polarity and the resulting code, the 12-cycle frame length and back-to-back chaining, the two-cycle arming, completion of a frame after the request drops, and the return to idle.

// File: rtl/sar_seq_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sar_seq_pkg;

    // Top-level control states of the frame timer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sar_frame_timer.sv
// Frame timer: it sequences idle -> arming -> repeated fixed-length frames
// and decodes the frame phase into sample, bit, and end-of-conversion windows.
// Assumes: FRAME_CYC >= SAMPLE_CYC + NBITS + 1. Any spare cycles after the
// end cycle are idle settle cycles with the preamplifier held in reset.
module sar_frame_timer
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS      = 8,
    parameter int unsigned SAMPLE_CYC = 3,
    parameter int unsigned FRAME_CYC  = 12,
    parameter int unsigned ARM_CYC    = 2,
    localparam int unsigned PH_W      = $clog2(FRAME_CYC),
    localparam int unsigned IDX_W     = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    output logic             arming,
    output logic             samp_on,
    output logic             bit_active,
    output logic             is_lsb,
    output logic [IDX_W-1:0] bit_idx,
    output logic             eoc,
    output logic             pre_rst
);

    localparam int unsigned AW     = $clog2(ARM_CYC + 1);
    localparam int unsigned EOC_PH = SAMPLE_CYC + NBITS;
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(FRAME_CYC - 1);
    localparam logic [PH_W-1:0] PH_SAMP  = PH_W'(SAMPLE_CYC);
    localparam logic [PH_W-1:0] PH_EOC   = PH_W'(EOC_PH);
    localparam logic [PH_W-1:0] PH_LSB   = PH_W'(EOC_PH - 1);
    localparam logic [AW-1:0]   ARM_LAST = AW'(ARM_CYC - 1);

    seq_state_t      state;
    logic [PH_W-1:0] phase;
    logic [AW-1:0]   arm_cnt;
    logic            in_run;

    // Advance the control state, the arming count and the frame phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= '0;
            arm_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run_en) begin
                        state   <= ST_ARM;
                        arm_cnt <= '0;
                    end
                end
                ST_ARM: begin
                    if (arm_cnt == ARM_LAST) begin
                        state <= ST_RUN;
                        phase <= '0;
                    end else begin
                        arm_cnt <= arm_cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (phase == PH_LAST) begin
                        phase <= '0;
                        if (!run_en) state <= ST_IDLE;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the phase into the per-window controls.
    always_comb begin
        in_run     = (state == ST_RUN);
        arming     = (state == ST_ARM);
        samp_on    = in_run && (phase < PH_SAMP);
        bit_active = in_run && (phase >= PH_SAMP) && (phase < PH_EOC);
        is_lsb     = in_run && (phase == PH_LSB);
        eoc        = in_run && (phase == PH_EOC);
        pre_rst    = in_run && !bit_active;
        bit_idx    = IDX_W'(PH_LSB - phase);
    end

endmodule

// File: rtl/sar_bit_register.sv
// Successive-approximation register: it builds the trial word, records each
// comparator decision and loads the result in one step on the LSB decision.
// Assumes: a comparator output of 1 means the trial word is above the input.
// The working bits are cleared during the sample window.
module sar_bit_register #(
    parameter int unsigned NBITS  = 8,
    localparam int unsigned IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_on,
    input  logic             bit_active,
    input  logic             is_lsb,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_out,
    output logic [NBITS-1:0] dac_word,
    output logic [NBITS-1:0] result
);

    logic [NBITS-1:0] work;
    logic [NBITS-1:0] hit;
    logic [NBITS-1:0] trial;
    logic [NBITS-1:0] decided;

    // Per-bit trial and decision slices.
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        assign hit[b]     = bit_active && (bit_idx == IDX_W'(b));
        assign trial[b]   = work[b] | hit[b];
        assign decided[b] = hit[b] ? ~cmp_out : work[b];
    end

    // Drive the switches only during bit trials; ground them otherwise.
    assign dac_word = bit_active ? trial : '0;

    // Keep the decided bits of the running conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work <= '0;
        end else if (samp_on) begin
            work <= '0;
        end else if (bit_active) begin
            work <= decided;
        end
    end

    // Load the finished code in one step when the LSB is decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (is_lsb) begin
            result <= decided;
        end
    end

endmodule

// File: rtl/sar_conv_seq.sv
// Top of the conversion sequencer: it joins the frame timer and the
// approximation register and exposes the switch and strobe controls.
// Assumes: run_en and cmp_out are synchronous to clk.
module sar_conv_seq #(
    parameter int unsigned NBITS      = 8,
    parameter int unsigned SAMPLE_CYC = 3,
    parameter int unsigned FRAME_CYC  = 12,
    parameter int unsigned ARM_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cmp_out,
    output logic             arming,
    output logic             samp_on,
    output logic             pre_rst,
    output logic             lat_stb,
    output logic [NBITS-1:0] dac_word,
    output logic             eoc,
    output logic [NBITS-1:0] result
);

    localparam int unsigned IDX_W = $clog2(NBITS);

    logic             bit_active;
    logic             is_lsb;
    logic [IDX_W-1:0] bit_idx;

    sar_frame_timer #(
        .NBITS      (NBITS),
        .SAMPLE_CYC (SAMPLE_CYC),
        .FRAME_CYC  (FRAME_CYC),
        .ARM_CYC    (ARM_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .arming     (arming),
        .samp_on    (samp_on),
        .bit_active (bit_active),
        .is_lsb     (is_lsb),
        .bit_idx    (bit_idx),
        .eoc        (eoc),
        .pre_rst    (pre_rst)
    );

    sar_bit_register #(
        .NBITS (NBITS)
    ) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_on    (samp_on),
        .bit_active (bit_active),
        .is_lsb     (is_lsb),
        .bit_idx    (bit_idx),
        .cmp_out    (cmp_out),
        .dac_word   (dac_word),
        .result     (result)
    );

    // The latch strobes once per bit decision.
    assign lat_stb = bit_active;

endmodule

// File: rtl/sar_conv_seq_chk.sv
// Checker for sar_conv_seq: it checks per-cycle relations between the
// outputs. It is bound to the top module below.
module sar_conv_seq_chk #(
    parameter int unsigned NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             cmp_out,
    input logic             arming,
    input logic             samp_on,
    input logic             pre_rst,
    input logic             lat_stb,
    input logic [NBITS-1:0] dac_word,
    input logic             eoc,
    input logic [NBITS-1:0] result
);

    assert_phases_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arming, samp_on, lat_stb, eoc}));

    assert_sample_grounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        samp_on |-> (dac_word == '0));

    assert_trial_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lat_stb |-> (dac_word != '0));

    assert_strobes_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_rst && lat_stb));

    assert_eoc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    assert_eoc_after_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> $past(lat_stb));

    assert_result_moves_on_eoc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> eoc);

    assert_arm_into_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arming) |-> samp_on);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sar_conv_seq_test.sv
// Bench for sar_conv_seq: a behavioural comparator against an input code,
// directed corner codes plus seeded random codes, and checks computed from
// the requirements.
module sar_conv_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       cmp_out;
    logic       arming, samp_on, pre_rst, lat_stb, eoc;
    logic [7:0] dac_word, result;
    logic [7:0] vin = 8'd0;
    logic [7:0] prev_code = 8'd0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    // Behavioural comparator: 1 when the trial word is above the input.
    assign cmp_out = (dac_word > vin);

    sar_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmp_out(cmp_out),
        .arming(arming), .samp_on(samp_on), .pre_rst(pre_rst),
        .lat_stb(lat_stb), .dac_word(dac_word), .eoc(eoc), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected trial word for bit i of code v: higher bits kept, bit i set.
    function automatic int trial_of(input int v, input int i);
        return ((v >> (i + 1)) << (i + 1)) | (1 << i);
    endfunction

    task automatic check_idle(input string req);
        check({req, " arming"}, int'(arming), 0);
        check({req, " samp_on"}, int'(samp_on), 0);
        check({req, " pre_rst"}, int'(pre_rst), 0);
        check({req, " lat_stb"}, int'(lat_stb), 0);
        check({req, " eoc"}, int'(eoc), 0);
    endtask

    // Check one frame from its first sample cycle. On return the bench sits
    // in the cycle after the end cycle.
    task automatic run_frame(input logic [7:0] code, input logic keep_on,
                             input int drop_at, input logic [7:0] next_code);
        vin = code;
        for (int p = 0; p < 12; p++) begin
            if (p == drop_at) run_en = 1'b0;
            if (p < 3) begin
                check("R4 samp_on", int'(samp_on), 1);
                check("R4 dac_word grounded", int'(dac_word), 0);
                check("R7 pre_rst in sample", int'(pre_rst), 1);
                check("R9 result held", int'(result), int'(prev_code));
            end else if (p < 11) begin
                check("R7 lat_stb in bit cycle", int'(lat_stb), 1);
                check("R7 pre_rst low in bit cycle", int'(pre_rst), 0);
                check("R5 trial word", int'(dac_word), trial_of(int'(code), 10 - p));
                check("R3 no eoc mid-frame", int'(eoc), 0);
            end else begin
                check("R8 eoc", int'(eoc), 1);
                check("R7 lat_stb in end cycle", int'(lat_stb), 0);
                check("R6 result code", int'(result), int'(code));
                prev_code = code;
                vin = next_code;
                if (!keep_on) run_en = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        check("R1 result in reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");
        run_en = 1'b1;
        @(negedge clk);
        check("R2 arming cycle 1", int'(arming), 1);
        check("R2 no sample while arming", int'(samp_on), 0);
        @(negedge clk);
        check("R2 arming cycle 2", int'(arming), 1);
        @(negedge clk);
        check("R2 arming ends", int'(arming), 0);
        // Directed corner codes, back to back (R3 chaining).
        run_frame(8'h00, 1'b1, -1, 8'hFF);
        run_frame(8'hFF, 1'b1, -1, 8'h80);
        run_frame(8'h80, 1'b1, -1, 8'h7F);
        run_frame(8'h7F, 1'b1, -1, 8'h55);
        run_frame(8'h55, 1'b1, -1, 8'h01);
        run_frame(8'h01, 1'b1, -1, 8'hFE);
        run_frame(8'hFE, 1'b1, -1, 8'($urandom));
        // Random codes.
        for (int k = 0; k < 20; k++) begin
            run_frame(vin, 1'b1, -1, 8'($urandom));
        end
        // R10: the request drops mid-frame, the frame still completes.
        run_frame(vin, 1'b0, 5, 8'hAA);
        for (int k = 0; k < 4; k++) begin
            check_idle("R10 idle after drop");
            check("R9 result held in idle", int'(result), int'(prev_code));
            @(negedge clk);
        end
        run_en = 1'b1;
        @(negedge clk);
        check("R10 re-arm cycle 1", int'(arming), 1);
        @(negedge clk);
        check("R10 re-arm cycle 2", int'(arming), 1);
        check("R9 result held while arming", int'(result), int'(prev_code));
        @(negedge clk);
        run_frame(8'hAA, 1'b1, -1, 8'h3C);
        // R1: reset applied in the middle of a frame.
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-frame reset");
        check("R1 dac_word after reset", int'(dac_word), 0);
        check("R1 result after reset", int'(result), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

endmodule